// File: doc/BRIEF.md
# Row-Scanned Burst Spike Encoder

This block turns a stored binary grid into parallel spike trains that drive the input layer of a spiking neural network. It has one spike line for each grid column and walks through the grid one row at a time. Every row is held for a programmable number of clock cycles, called the sample period. During that period each column whose pixel is set emits a short burst of single-cycle spikes. A column whose pixel is clear stays silent.

A one-cycle start pulse captures the flat pattern vector, the inversion select and the sample period, then begins the scan at row 0. When inversion is selected, the complement of every pixel is encoded. A one-cycle done pulse marks the end of the last row's period. The grid height and width are parameters. The pattern arrives row-major: pixel (row r, column c) is bit r*COLS+c.

Top module: `spike_row_encoder`

## Requirements
- R1: After reset, spike_o is all zero and busy_o and done_o are low.
- R2: A start_i pulse sampled while busy_o is low captures pattern_i, invert_i and period_i. busy_o is high from the next cycle, and that cycle is cycle 0 of row 0.
- R3: In cycles 0, 2 and 4 of a row period, spike_o[c] equals the encoded pixel (current row, column c), which is bit row*COLS+c of the captured pattern. In every other cycle of the period, spike_o is zero. A set pixel therefore gives exactly three spikes and a clear pixel gives none.
- R4: Rows are presented in order 0 to ROWS-1, each for exactly the effective period, with no gap between rows.
- R5: The effective period is the captured period_i, but any value below 6 (including 0) is treated as 6.
- R6: With invert_i captured high, every pixel is complemented before encoding.
- R7: A start_i pulse while busy_o is high is ignored. The captured pattern, inversion, period and scan timing all stay unchanged.
- R8: done_o is high for exactly one cycle: the cycle right after the last cycle of row ROWS-1. busy_o is low in that same cycle.
- R9: spike_o is zero whenever busy_o is low, and no line ever spikes in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, acted on only when idle |
| invert_i | input | 1 | Encode the complement of the pattern |
| pattern_i | input | ROWS*COLS | Flat row-major grid, bit r*COLS+c |
| period_i | input | PERIOD_W | Sample period per row in cycles (minimum 6 applied) |
| spike_o | output | COLS | One spike line per column |
| busy_o | output | 1 | High while a scan is running |
| done_o | output | 1 | One-cycle pulse after the final row period |

## Verification
The start pulse is registered once, so the first spike of row 0 appears in the cycle right after the edge that samples start_i. Spike k of row r is due at cycle r*P + 2k after that edge, and done_o is due at cycle ROWS*P. The bench drives every input on the falling edge and samples on the falling edge. It counts cycles from the start edge and compares spike_o against a value computed from this cycle arithmetic in every cycle of the scan. The done and busy checks are placed exactly at cycle ROWS*P and at the cycle after it.

// File: rtl/spk_enc_pkg.sv
package spk_enc_pkg;
  localparam int unsigned BURST_LEN  = 3;
  localparam int unsigned MIN_PERIOD = 2 * BURST_LEN;

  // Spike slots sit on even phases at the head of the row period.
  function automatic logic in_burst(input int unsigned phase);
    return (phase < MIN_PERIOD) && (phase % 2 == 0);
  endfunction

  // Apply the minimum period that still fits the burst.
  function automatic int unsigned effective_period(input int unsigned req);
    return (req < MIN_PERIOD) ? MIN_PERIOD : req;
  endfunction
endpackage

// File: rtl/spk_pattern_store.sv
module spk_pattern_store #(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 invert_i,
  input  logic [ROWS*COLS-1:0] pattern_i,
  input  logic [ROW_W-1:0]     row_idx_i,
  output logic [COLS-1:0]      row_bits_o
);
  logic [ROWS*COLS-1:0] pat_q;
  logic [COLS-1:0]      row_w [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_q <= '0;
    else if (load_i) pat_q <= invert_i ? ~pattern_i : pattern_i;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_w[r] = pat_q[r*COLS +: COLS];
  end

  assign row_bits_o = row_w[row_idx_i];
endmodule

// File: rtl/spk_timebase.sv
module spk_timebase
  import spk_enc_pkg::*;
#(
  parameter int ROWS     = 5,
  parameter int PERIOD_W = 8,
  parameter int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                load_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [ROW_W-1:0]    row_idx_o,
  output logic [PERIOD_W-1:0] phase_o,
  output logic [PERIOD_W-1:0] period_eff_o,
  output logic                row_end_o,
  output logic                scan_end_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic                busy_q, done_q;
  logic [ROW_W-1:0]    row_q;
  logic [PERIOD_W-1:0] phase_q, period_q;

  assign load_o     = start_i && !busy_q;
  assign row_end_o  = busy_q && (phase_q == period_q - PERIOD_W'(1));
  assign scan_end_o = row_end_o && (row_q == LAST_ROW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      row_q    <= '0;
      phase_q  <= '0;
      period_q <= PERIOD_W'(MIN_PERIOD);
    end else begin
      done_q <= scan_end_o;
      if (load_o) begin
        busy_q   <= 1'b1;
        row_q    <= '0;
        phase_q  <= '0;
        period_q <= PERIOD_W'(effective_period(32'(period_i)));
      end else if (busy_q) begin
        if (scan_end_o) begin
          busy_q  <= 1'b0;
          phase_q <= '0;
          row_q   <= '0;
        end else if (row_end_o) begin
          phase_q <= '0;
          row_q   <= row_q + ROW_W'(1);
        end else begin
          phase_q <= phase_q + PERIOD_W'(1);
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign row_idx_o    = row_q;
  assign phase_o      = phase_q;
  assign period_eff_o = period_q;
endmodule

// File: rtl/spk_burst_gen.sv
module spk_burst_gen
  import spk_enc_pkg::*;
#(
  parameter int COLS     = 5,
  parameter int PERIOD_W = 8
) (
  input  logic                busy_i,
  input  logic [PERIOD_W-1:0] phase_i,
  input  logic [COLS-1:0]     row_bits_i,
  output logic                fire_slot_o,
  output logic [COLS-1:0]     spike_o
);
  assign fire_slot_o = busy_i && in_burst(32'(phase_i));

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign spike_o[c] = fire_slot_o && row_bits_i[c];
  end
endmodule

// File: rtl/spike_row_encoder.sv
module spike_row_encoder #(
  parameter int ROWS     = 5,
  parameter int COLS     = 5,
  parameter int PERIOD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 invert_i,
  input  logic [ROWS*COLS-1:0] pattern_i,
  input  logic [PERIOD_W-1:0]  period_i,
  output logic [COLS-1:0]      spike_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic                load_w, row_end_w, scan_end_w, fire_slot_w;
  logic [ROW_W-1:0]    row_idx_w;
  logic [PERIOD_W-1:0] phase_w, period_eff_w;
  logic [COLS-1:0]     row_bits_w;

  spk_timebase #(.ROWS(ROWS), .PERIOD_W(PERIOD_W), .ROW_W(ROW_W)) u_time (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_i(period_i),
    .load_o(load_w), .busy_o(busy_o), .done_o(done_o),
    .row_idx_o(row_idx_w), .phase_o(phase_w), .period_eff_o(period_eff_w),
    .row_end_o(row_end_w), .scan_end_o(scan_end_w)
  );

  spk_pattern_store #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .invert_i(invert_i),
    .pattern_i(pattern_i), .row_idx_i(row_idx_w), .row_bits_o(row_bits_w)
  );

  spk_burst_gen #(.COLS(COLS), .PERIOD_W(PERIOD_W)) u_burst (
    .busy_i(busy_o), .phase_i(phase_w), .row_bits_i(row_bits_w),
    .fire_slot_o(fire_slot_w), .spike_o(spike_o)
  );
endmodule

// File: rtl/spk_encoder_checker.sv
module spk_encoder_checker #(
  parameter int ROWS     = 5,
  parameter int COLS     = 5,
  parameter int PERIOD_W = 8,
  parameter int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [COLS-1:0]     spike_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [ROW_W-1:0]    row_idx,
  input logic [PERIOD_W-1:0] phase,
  input logic [PERIOD_W-1:0] period_eff,
  input logic                row_end,
  input logic                scan_end
);
  assert_spike_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spike_o != '0) |-> busy_o);

  assert_spike_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spike_o != '0) |=> (spike_o == '0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |=> (done_o && !busy_o));

  assert_start_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && row_idx == '0 && phase == '0));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !scan_end) |=> (busy_o && $stable(period_eff)));

  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (phase < period_eff && period_eff >= PERIOD_W'(6)));

  assert_row_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && !scan_end) |=> (row_idx == $past(row_idx) + ROW_W'(1) && phase == '0));
endmodule

bind spike_row_encoder spk_encoder_checker #(
  .ROWS(ROWS), .COLS(COLS), .PERIOD_W(PERIOD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .spike_o(spike_o),
  .busy_o(busy_o), .done_o(done_o), .row_idx(row_idx_w), .phase(phase_w),
  .period_eff(period_eff_w), .row_end(row_end_w), .scan_end(scan_end_w)
);

// File: tb/spike_row_encoder_test.sv
module spike_row_encoder_test;
  localparam int ROWS = 5;
  localparam int COLS = 5;
  localparam int PW   = 8;
  localparam int NB   = ROWS * COLS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic            invert_i = 1'b0;
  logic [NB-1:0]   pattern_i = '0;
  logic [PW-1:0]   period_i = '0;
  logic [COLS-1:0] spike_o;
  logic            busy_o, done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spike_row_encoder #(.ROWS(ROWS), .COLS(COLS), .PERIOD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .invert_i(invert_i),
    .pattern_i(pattern_i), .period_i(period_i),
    .spike_o(spike_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent restatement: cycle t after the start edge.
  function automatic logic [COLS-1:0] want_spike(input logic [NB-1:0] pat, input bit inv,
                                                  input int per, input int t);
    int row = t / per;
    int ph  = t % per;
    logic [COLS-1:0] bits = pat[row*COLS +: COLS];
    if (inv) bits = ~bits;
    if (ph == 0 || ph == 2 || ph == 4) return bits;
    return '0;
  endfunction

  // One full scan; disturb pulses a conflicting start mid-scan.
  task automatic run_scan(input string req, input logic [NB-1:0] pat, input bit inv,
                          input int per, input bit disturb);
    int eff = (per < 6) ? 6 : per;
    int bad = 0;
    int spikes = 0;
    logic [COLS-1:0] e;
    @(negedge clk);
    pattern_i = pat; invert_i = inv; period_i = PW'(per); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " R2 busy after start"}, 32'(busy_o), 1);
    for (int t = 0; t < ROWS * eff; t++) begin
      e = want_spike(pat, inv, eff, t);
      if (spike_o !== e) begin
        if (bad == 0)
          $display("FAIL %s R3/R4 cycle %0d spike actual=%0h expected=%0h", req, t, spike_o, e);
        bad++;
      end
      spikes += $countones(spike_o);
      if (busy_o !== 1'b1 || done_o !== 1'b0) bad++;
      if (disturb && t == eff + 1) begin
        start_i = 1'b1; pattern_i = ~pat; invert_i = ~inv; period_i = PW'(eff + 3);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s R3/R4 scan mismatches actual=%0d expected=0", req, bad);
    end
    chk({req, " R8 done at end"}, 32'(done_o), 1);
    chk({req, " R8 busy low at done"}, 32'(busy_o), 0);
    chk({req, " R9 no spike idle"}, 32'(spike_o), 0);
    begin
      int ones = 0;
      for (int i = 0; i < NB; i++) ones += ((pat[i] ^ inv) ? 1 : 0);
      chk({req, " R3 three spikes per set pixel"}, 32'(spikes), 32'(3 * ones));
    end
    @(negedge clk);
    chk({req, " R8 done single cycle"}, 32'(done_o), 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 spike reset", 32'(spike_o), 0);
    chk("R1 busy reset", 32'(busy_o), 0);
    chk("R1 done reset", 32'(done_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 32'({spike_o, busy_o, done_o}), 0);
  endtask

  task automatic t_plus();   run_scan("plus P6 R3",      25'h0423880, 1'b0, 6, 1'b0); endtask
  task automatic t_invert(); run_scan("invert P8 R6",    25'h1151151, 1'b1, 8, 1'b0); endtask
  task automatic t_ignore(); run_scan("busy start R7",   25'h1F0A5C3, 1'b0, 10, 1'b1); endtask
  task automatic t_clamp();  run_scan("short period R5", 25'h1FFFFFF, 1'b0, 3, 1'b0); endtask
  task automatic t_zero();   run_scan("zero period R5",  25'h0000001, 1'b0, 0, 1'b0); endtask
  task automatic t_blank();  run_scan("blank R3 R9",     25'h0000000, 1'b0, 7, 1'b0); endtask

  initial begin
    t_reset();
    t_plus();
    t_invert();
    t_ignore();
    t_clamp();
    t_zero();
    t_blank();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule